// File: doc/BRIEF.md
# MMU Configuration and Fault Register Bank

This block holds the settings and the fault record for a processor's address-translation unit. The processor reaches it through a coprocessor access port that names one register by a 4-bit number. A write is committed at the clock edge where it is presented. A read returns its data combinationally in the same cycle. The port has no back-pressure, so every access completes in the cycle it is offered. The translation logic has its own abort-capture input. It is a single-cycle event with no ready: it is always accepted, and it records the domain, the fault code and the faulting address. The bank drives the live configuration to the translation logic: the enable bits, the aligned table base and the per-domain permission fields.

One register number stores nothing. A write to it produces a one-cycle TLB maintenance pulse on the following cycle. The pulse either flushes the whole TLB or removes the single entry that matches the address written with it. A secondary opcode chooses which. Reads of that number, and any access to a number the bank does not implement, return zero and raise an undefined-access flag.

Top module: `mmu_cfg_regbank`

## Requirements
- R1: Register 1 keeps four bits: bit 0 enables translation (`ctl_mmu_en`), bit 1 enables alignment checks (`ctl_align_chk`), bit 8 and bit 9 select the protection scheme (`ctl_sys_prot`, `ctl_rom_prot`). All other bits read back as zero. The outputs change only on a write to register 1 or on reset.
- R2: Register 2 keeps bits 31:14 of the written word and reads back with bits 13:0 zero. `ttb_base` shows the same value from the cycle after the write.
- R3: Register 3 is 32 bits wide. Domain n owns bits 2n+1:2n. The full word reads back unchanged and appears on `dom_perm` from the cycle after the write.
- R4: Register 5 keeps 8 bits: the domain number in bits 7:4 and the fault code in bits 3:0. Bits 31:8 read as zero.
- R5: Register 6 keeps a full 32-bit fault address that software can write and read back.
- R6: When `abt_valid` is high at a clock edge, register 5 loads {`abt_domain`,`abt_ftype`} and register 6 loads `abt_addr`.
- R7: If a software write to register 5 or 6 falls in the same cycle as an abort, the abort values are stored and the software value is dropped.
- R8: A write to register 8 stores nothing. With opcode 0 it raises `tlb_inv_all` for exactly the next cycle. With opcode 1 it raises `tlb_inv_one` for exactly the next cycle and places the written word on `tlb_inv_addr`. The two pulses never overlap.
- R9: A read of register 8 or of any number other than 1, 2, 3, 5 or 6 returns zero with `cp_undef` high. A write to an unimplemented number, or to register 8 with an opcode other than 0 or 1, changes no state, produces no pulse and raises `cp_undef`.
- R10: Reset (active low, asynchronous) clears every stored register and both pulse outputs to zero.
- R11: Read data is valid in the same cycle as `cp_rd_en` and is zero whenever `cp_rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cp_wr_en | input | 1 | Software write strobe |
| cp_rd_en | input | 1 | Software read strobe |
| cp_regnum | input | 4 | Register number |
| cp_opc2 | input | 3 | Secondary opcode (selects the register 8 operation) |
| cp_wdata | input | 32 | Write data |
| cp_rdata | output | 32 | Read data, combinational |
| cp_undef | output | 1 | Access to an unreadable or unimplemented register |
| abt_valid | input | 1 | Abort capture strobe |
| abt_domain | input | 4 | Domain of the aborted access |
| abt_ftype | input | 4 | Fault type code |
| abt_addr | input | 32 | Address of the aborted access |
| ctl_mmu_en | output | 1 | Translation enable |
| ctl_align_chk | output | 1 | Alignment check enable |
| ctl_sys_prot | output | 1 | Protection scheme select, system |
| ctl_rom_prot | output | 1 | Protection scheme select, ROM |
| ttb_base | output | 32 | Translation table base, 16 KB aligned |
| dom_perm | output | 32 | Sixteen 2-bit domain permission fields |
| tlb_inv_all | output | 1 | One-cycle flush-all pulse |
| tlb_inv_one | output | 1 | One-cycle single-entry invalidate pulse |
| tlb_inv_addr | output | 32 | Address qualifier for the maintenance pulse |

## Verification
The bound checker watches the following on every cycle: abort capture into both fault registers, and abort priority over a colliding software write. It also checks that maintenance pulses are exclusive and always caused by a register 8 write. Finally it checks that register 8 reads come back zero with the flag raised, that table base and domain fields load from write data, and that the control outputs stay stable without a write. Some behaviour only the bench scenarios can show: the masked read-back of each register and ignored writes to unimplemented numbers. The same goes for pulses that last one cycle and then drop, a bad register 8 opcode that gives no pulse, and a reset in mid-run that clears state software had set.

// File: rtl/mmu_cfg_pkg.sv
package mmu_cfg_pkg;

  localparam int CP_SEL_W = 4;
  localparam int CP_OP2_W = 3;

  // register numbers seen on the coprocessor port
  localparam logic [CP_SEL_W-1:0] RN_CTL   = 4'd1;
  localparam logic [CP_SEL_W-1:0] RN_TTB   = 4'd2;
  localparam logic [CP_SEL_W-1:0] RN_DAC   = 4'd3;
  localparam logic [CP_SEL_W-1:0] RN_FSR   = 4'd5;
  localparam logic [CP_SEL_W-1:0] RN_FAR   = 4'd6;
  localparam logic [CP_SEL_W-1:0] RN_TLBOP = 4'd8;

  // secondary opcode values for the maintenance register
  localparam logic [CP_OP2_W-1:0] TLBOP_ALL = 3'd0;
  localparam logic [CP_OP2_W-1:0] TLBOP_ONE = 3'd1;

  // bit positions inside the control word
  localparam int CTL_M_BIT = 0;
  localparam int CTL_A_BIT = 1;
  localparam int CTL_S_BIT = 8;
  localparam int CTL_R_BIT = 9;

  typedef struct packed {
    logic ctl;
    logic ttb;
    logic dac;
    logic fsr;
    logic far;
    logic inv_all;
    logic inv_one;
  } wr_strobe_t;

  typedef enum logic [2:0] {
    RSEL_NONE,
    RSEL_CTL,
    RSEL_TTB,
    RSEL_DAC,
    RSEL_FSR,
    RSEL_FAR
  } rd_sel_e;

endpackage

// File: rtl/mmu_cfg_decode.sv
module mmu_cfg_decode
  import mmu_cfg_pkg::*;
(
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [CP_SEL_W-1:0] regnum,
  input  logic [CP_OP2_W-1:0] opc2,
  output wr_strobe_t          wr_stb,
  output rd_sel_e             rd_sel,
  output logic                undef
);

  logic wr_ok;
  logic rd_ok;

  always_comb begin
    wr_stb = '0;
    rd_sel = RSEL_NONE;
    wr_ok  = 1'b0;
    rd_ok  = 1'b0;
    case (regnum)
      RN_CTL: begin
        wr_stb.ctl = wr_en;
        rd_sel     = RSEL_CTL;
        wr_ok      = 1'b1;
        rd_ok      = 1'b1;
      end
      RN_TTB: begin
        wr_stb.ttb = wr_en;
        rd_sel     = RSEL_TTB;
        wr_ok      = 1'b1;
        rd_ok      = 1'b1;
      end
      RN_DAC: begin
        wr_stb.dac = wr_en;
        rd_sel     = RSEL_DAC;
        wr_ok      = 1'b1;
        rd_ok      = 1'b1;
      end
      RN_FSR: begin
        wr_stb.fsr = wr_en;
        rd_sel     = RSEL_FSR;
        wr_ok      = 1'b1;
        rd_ok      = 1'b1;
      end
      RN_FAR: begin
        wr_stb.far = wr_en;
        rd_sel     = RSEL_FAR;
        wr_ok      = 1'b1;
        rd_ok      = 1'b1;
      end
      RN_TLBOP: begin
        // command port: never readable
        if (opc2 == TLBOP_ALL) begin
          wr_stb.inv_all = wr_en;
          wr_ok          = 1'b1;
        end else if (opc2 == TLBOP_ONE) begin
          wr_stb.inv_one = wr_en;
          wr_ok          = 1'b1;
        end
      end
      default: ;
    endcase
    undef = (rd_en & ~rd_ok) | (wr_en & ~wr_ok);
  end

endmodule

// File: rtl/mmu_cfg_fault.sv
module mmu_cfg_fault #(
  parameter int ADDR_W    = 32,
  parameter int DOM_IDX_W = 4,
  parameter int FT_W      = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sw_fsr_we,
  input  logic                      sw_far_we,
  input  logic [ADDR_W-1:0]         sw_wdata,
  input  logic                      abt_valid,
  input  logic [DOM_IDX_W-1:0]      abt_domain,
  input  logic [FT_W-1:0]           abt_ftype,
  input  logic [ADDR_W-1:0]         abt_addr,
  output logic [DOM_IDX_W+FT_W-1:0] fsr_q,
  output logic [ADDR_W-1:0]         far_q
);

  localparam int FSR_W = DOM_IDX_W + FT_W;

  // hardware capture outranks a software write in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsr_q <= '0;
      far_q <= '0;
    end else if (abt_valid) begin
      fsr_q <= {abt_domain, abt_ftype};
      far_q <= abt_addr;
    end else begin
      if (sw_fsr_we) fsr_q <= sw_wdata[FSR_W-1:0];
      if (sw_far_we) far_q <= sw_wdata;
    end
  end

endmodule

// File: rtl/mmu_cfg_tlbcmd.sv
module mmu_cfg_tlbcmd #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              all_stb,
  input  logic              one_stb,
  input  logic [ADDR_W-1:0] wdata,
  output logic              inv_all,
  output logic              inv_one,
  output logic [ADDR_W-1:0] inv_addr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inv_all  <= 1'b0;
      inv_one  <= 1'b0;
      inv_addr <= '0;
    end else begin
      inv_all <= all_stb;
      inv_one <= one_stb;
      if (all_stb || one_stb) inv_addr <= wdata;
    end
  end

endmodule

// File: rtl/mmu_cfg_regbank.sv
module mmu_cfg_regbank
  import mmu_cfg_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DOM_N   = 16,
  parameter int FT_W    = 4,
  parameter int TTB_LSB = 14
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cp_wr_en,
  input  logic                     cp_rd_en,
  input  logic [CP_SEL_W-1:0]      cp_regnum,
  input  logic [CP_OP2_W-1:0]      cp_opc2,
  input  logic [ADDR_W-1:0]        cp_wdata,
  output logic [ADDR_W-1:0]        cp_rdata,
  output logic                     cp_undef,
  input  logic                     abt_valid,
  input  logic [$clog2(DOM_N)-1:0] abt_domain,
  input  logic [FT_W-1:0]          abt_ftype,
  input  logic [ADDR_W-1:0]        abt_addr,
  output logic                     ctl_mmu_en,
  output logic                     ctl_align_chk,
  output logic                     ctl_sys_prot,
  output logic                     ctl_rom_prot,
  output logic [ADDR_W-1:0]        ttb_base,
  output logic [2*DOM_N-1:0]       dom_perm,
  output logic                     tlb_inv_all,
  output logic                     tlb_inv_one,
  output logic [ADDR_W-1:0]        tlb_inv_addr
);

  localparam int DOM_IDX_W = $clog2(DOM_N);
  localparam int FSR_W     = DOM_IDX_W + FT_W;
  localparam int TTB_W     = ADDR_W - TTB_LSB;

  wr_strobe_t        wr_stb;
  rd_sel_e           rd_sel;
  logic [ADDR_W-1:0] rd_word;
  logic [TTB_W-1:0]  ttb_q;
  logic [FSR_W-1:0]  fault_status;
  logic [ADDR_W-1:0] fault_addr;

  mmu_cfg_decode u_decode (
    .wr_en  (cp_wr_en),
    .rd_en  (cp_rd_en),
    .regnum (cp_regnum),
    .opc2   (cp_opc2),
    .wr_stb (wr_stb),
    .rd_sel (rd_sel),
    .undef  (cp_undef)
  );

  // control bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_mmu_en    <= 1'b0;
      ctl_align_chk <= 1'b0;
      ctl_sys_prot  <= 1'b0;
      ctl_rom_prot  <= 1'b0;
    end else if (wr_stb.ctl) begin
      ctl_mmu_en    <= cp_wdata[CTL_M_BIT];
      ctl_align_chk <= cp_wdata[CTL_A_BIT];
      ctl_sys_prot  <= cp_wdata[CTL_S_BIT];
      ctl_rom_prot  <= cp_wdata[CTL_R_BIT];
    end
  end

  // table base: only the aligned upper bits are kept
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ttb_q <= '0;
    else if (wr_stb.ttb) ttb_q <= cp_wdata[ADDR_W-1:TTB_LSB];
  end
  assign ttb_base = {ttb_q, {TTB_LSB{1'b0}}};

  // one 2-bit permission field per domain
  for (genvar d = 0; d < DOM_N; d++) begin : g_dom
    logic [1:0] field_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          field_q <= 2'b00;
      else if (wr_stb.dac) field_q <= cp_wdata[2*d +: 2];
    end
    assign dom_perm[2*d +: 2] = field_q;
  end

  mmu_cfg_fault #(
    .ADDR_W    (ADDR_W),
    .DOM_IDX_W (DOM_IDX_W),
    .FT_W      (FT_W)
  ) u_fault (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_fsr_we  (wr_stb.fsr),
    .sw_far_we  (wr_stb.far),
    .sw_wdata   (cp_wdata),
    .abt_valid  (abt_valid),
    .abt_domain (abt_domain),
    .abt_ftype  (abt_ftype),
    .abt_addr   (abt_addr),
    .fsr_q      (fault_status),
    .far_q      (fault_addr)
  );

  mmu_cfg_tlbcmd #(
    .ADDR_W (ADDR_W)
  ) u_tlbcmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .all_stb  (wr_stb.inv_all),
    .one_stb  (wr_stb.inv_one),
    .wdata    (cp_wdata),
    .inv_all  (tlb_inv_all),
    .inv_one  (tlb_inv_one),
    .inv_addr (tlb_inv_addr)
  );

  // read multiplexer
  always_comb begin
    rd_word = '0;
    case (rd_sel)
      RSEL_CTL: begin
        rd_word[CTL_M_BIT] = ctl_mmu_en;
        rd_word[CTL_A_BIT] = ctl_align_chk;
        rd_word[CTL_S_BIT] = ctl_sys_prot;
        rd_word[CTL_R_BIT] = ctl_rom_prot;
      end
      RSEL_TTB: rd_word = ttb_base;
      RSEL_DAC: rd_word = ADDR_W'(dom_perm);
      RSEL_FSR: rd_word = ADDR_W'(fault_status);
      RSEL_FAR: rd_word = fault_addr;
      default:  rd_word = '0;
    endcase
  end
  assign cp_rdata = cp_rd_en ? rd_word : '0;

endmodule

// File: rtl/mmu_cfg_regbank_chk.sv
module mmu_cfg_regbank_chk #(
  parameter int ADDR_W  = 32,
  parameter int DOM_N   = 16,
  parameter int FT_W    = 4,
  parameter int TTB_LSB = 14
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic                                cp_wr_en,
  input logic                                cp_rd_en,
  input logic [3:0]                          cp_regnum,
  input logic [ADDR_W-1:0]                   cp_wdata,
  input logic [ADDR_W-1:0]                   cp_rdata,
  input logic                                cp_undef,
  input logic                                abt_valid,
  input logic [$clog2(DOM_N)-1:0]            abt_domain,
  input logic [FT_W-1:0]                     abt_ftype,
  input logic [ADDR_W-1:0]                   abt_addr,
  input logic                                ctl_mmu_en,
  input logic                                ctl_align_chk,
  input logic                                ctl_sys_prot,
  input logic                                ctl_rom_prot,
  input logic [ADDR_W-1:0]                   ttb_base,
  input logic [2*DOM_N-1:0]                  dom_perm,
  input logic                                tlb_inv_all,
  input logic                                tlb_inv_one,
  input logic [$clog2(DOM_N)+FT_W-1:0]       fault_status,
  input logic [ADDR_W-1:0]                   fault_addr
);

  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(cp_wr_en && cp_regnum == 4'd1) |=> $stable({ctl_mmu_en, ctl_align_chk, ctl_sys_prot, ctl_rom_prot})); // R1
  AST_TTB_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_wr_en && cp_regnum == 4'd2) |=> ttb_base[ADDR_W-1:TTB_LSB] == $past(cp_wdata[ADDR_W-1:TTB_LSB])); // R2
  AST_DAC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_wr_en && cp_regnum == 4'd3) |=> dom_perm == $past(cp_wdata[2*DOM_N-1:0])); // R3
  AST_ABT_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    abt_valid |=> fault_status == $past({abt_domain, abt_ftype})); // R6
  AST_ABT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    abt_valid |=> fault_addr == $past(abt_addr)); // R6
  AST_ABT_BEATS_SW: assert property (@(posedge clk) disable iff (!rst_n)
    (abt_valid && cp_wr_en && (cp_regnum == 4'd5 || cp_regnum == 4'd6)) |=> fault_addr == $past(abt_addr)); // R7
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(tlb_inv_all && tlb_inv_one)); // R8
  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (tlb_inv_all || tlb_inv_one) |-> $past(cp_wr_en && cp_regnum == 4'd8)); // R8
  AST_RD_CMD_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_rd_en && cp_regnum == 4'd8) |-> (cp_undef && cp_rdata == '0)); // R9
  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !cp_rd_en |-> cp_rdata == '0); // R11

endmodule

bind mmu_cfg_regbank mmu_cfg_regbank_chk #(
  .ADDR_W  (ADDR_W),
  .DOM_N   (DOM_N),
  .FT_W    (FT_W),
  .TTB_LSB (TTB_LSB)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cp_wr_en      (cp_wr_en),
  .cp_rd_en      (cp_rd_en),
  .cp_regnum     (cp_regnum),
  .cp_wdata      (cp_wdata),
  .cp_rdata      (cp_rdata),
  .cp_undef      (cp_undef),
  .abt_valid     (abt_valid),
  .abt_domain    (abt_domain),
  .abt_ftype     (abt_ftype),
  .abt_addr      (abt_addr),
  .ctl_mmu_en    (ctl_mmu_en),
  .ctl_align_chk (ctl_align_chk),
  .ctl_sys_prot  (ctl_sys_prot),
  .ctl_rom_prot  (ctl_rom_prot),
  .ttb_base      (ttb_base),
  .dom_perm      (dom_perm),
  .tlb_inv_all   (tlb_inv_all),
  .tlb_inv_one   (tlb_inv_one),
  .fault_status  (fault_status),
  .fault_addr    (fault_addr)
);

// File: tb/tb_mmu_cfg_regbank.sv
`timescale 1ns/1ps
module tb_mmu_cfg_regbank;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cp_wr_en, cp_rd_en;
  logic [3:0]  cp_regnum;
  logic [2:0]  cp_opc2;
  logic [31:0] cp_wdata, cp_rdata;
  logic        cp_undef;
  logic        abt_valid;
  logic [3:0]  abt_domain, abt_ftype;
  logic [31:0] abt_addr;
  logic        ctl_mmu_en, ctl_align_chk, ctl_sys_prot, ctl_rom_prot;
  logic [31:0] ttb_base, dom_perm, tlb_inv_addr;
  logic        tlb_inv_all, tlb_inv_one;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  mmu_cfg_regbank dut (
    .clk(clk), .rst_n(rst_n),
    .cp_wr_en(cp_wr_en), .cp_rd_en(cp_rd_en), .cp_regnum(cp_regnum),
    .cp_opc2(cp_opc2), .cp_wdata(cp_wdata), .cp_rdata(cp_rdata), .cp_undef(cp_undef),
    .abt_valid(abt_valid), .abt_domain(abt_domain), .abt_ftype(abt_ftype), .abt_addr(abt_addr),
    .ctl_mmu_en(ctl_mmu_en), .ctl_align_chk(ctl_align_chk),
    .ctl_sys_prot(ctl_sys_prot), .ctl_rom_prot(ctl_rom_prot),
    .ttb_base(ttb_base), .dom_perm(dom_perm),
    .tlb_inv_all(tlb_inv_all), .tlb_inv_one(tlb_inv_one), .tlb_inv_addr(tlb_inv_addr)
  );

  typedef struct packed {
    logic        wr;
    logic [3:0]  wreg;
    logic [2:0]  wop;
    logic [31:0] wdata;
    logic [3:0]  rreg;
    logic [31:0] exp;
    logic        exp_undef;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 4'd1, 3'd0, 32'hFFFF_FFFF, 4'd1,  32'h0000_0303, 1'b0, 4'd1},  // R1 masked control bits
    '{1'b1, 4'd2, 3'd0, 32'hFFFF_FFFF, 4'd2,  32'hFFFF_C000, 1'b0, 4'd2},  // R2 low bits zero
    '{1'b1, 4'd3, 3'd0, 32'hA5C3_1E2D, 4'd3,  32'hA5C3_1E2D, 1'b0, 4'd3},  // R3 full word
    '{1'b1, 4'd5, 3'd0, 32'hFFFF_FFFF, 4'd5,  32'h0000_00FF, 1'b0, 4'd4},  // R4 eight bits kept
    '{1'b1, 4'd6, 3'd0, 32'h1234_5678, 4'd6,  32'h1234_5678, 1'b0, 4'd5},  // R5 fault address
    '{1'b1, 4'd1, 3'd0, 32'h0000_0201, 4'd1,  32'h0000_0201, 1'b0, 4'd1},  // R1 M and R set
    '{1'b0, 4'd0, 3'd0, 32'h0,         4'd8,  32'h0,         1'b1, 4'd9},  // R9 command reg unreadable
    '{1'b0, 4'd0, 3'd0, 32'h0,         4'd0,  32'h0,         1'b1, 4'd9},  // R9 number 0
    '{1'b0, 4'd0, 3'd0, 32'h0,         4'd15, 32'h0,         1'b1, 4'd9},  // R9 number 15
    '{1'b1, 4'd7, 3'd0, 32'hFFFF_FFFF, 4'd1,  32'h0000_0201, 1'b0, 4'd9},  // R9 write ignored
    '{1'b1, 4'd8, 3'd0, 32'hFFFF_FFFF, 4'd3,  32'hA5C3_1E2D, 1'b0, 4'd8},  // R8 stores nothing
    '{1'b1, 4'd2, 3'd0, 32'h0000_7FFF, 4'd2,  32'h0000_4000, 1'b0, 4'd2}   // R2 bit 14 kept only
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    cp_wr_en = 0; cp_rd_en = 0; cp_regnum = 0; cp_opc2 = 0; cp_wdata = 0;
    abt_valid = 0; abt_domain = 0; abt_ftype = 0; abt_addr = 0;
  endtask

  // write presented for one cycle; returns at the negedge after the capturing edge
  task automatic wr_reg(input logic [3:0] rn, input logic [2:0] op, input logic [31:0] d);
    @(negedge clk);
    cp_wr_en = 1; cp_regnum = rn; cp_opc2 = op; cp_wdata = d;
    @(negedge clk);
    cp_wr_en = 0; cp_opc2 = 0; cp_wdata = 0;
  endtask

  // combinational read sampled 1 ns after the inputs change
  task automatic rd_reg(input logic [3:0] rn, output logic [31:0] d, output logic u);
    cp_rd_en = 1; cp_regnum = rn;
    #1;
    d = cp_rdata; u = cp_undef;
    cp_rd_en = 0;
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic        u;
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 ctl", {28'd0, ctl_mmu_en, ctl_align_chk, ctl_sys_prot, ctl_rom_prot}, 32'h0);
    check("R10 ttb", ttb_base, 32'h0);
    check("R10 dom", dom_perm, 32'h0);
    check("R10 pulses", {30'd0, tlb_inv_all, tlb_inv_one}, 32'h0);
    rst_n = 1;
    @(negedge clk);
    rd_reg(4'd6, d, u);
    check("R10 far", d, 32'h0);
    check("R11 idle read", cp_rdata, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i].wr) wr_reg(VEC[i].wreg, VEC[i].wop, VEC[i].wdata);
      else @(negedge clk);
      rd_reg(VEC[i].rreg, d, u);
      check($sformatf("R%0d vec%0d data", VEC[i].req, i), d, VEC[i].exp);
      check($sformatf("R%0d vec%0d undef", VEC[i].req, i), {31'd0, u}, {31'd0, VEC[i].exp_undef});
    end

    // R1 outputs after control 0x201, R2 base, R3 domain 2 field
    check("R1 outputs", {28'd0, ctl_mmu_en, ctl_align_chk, ctl_sys_prot, ctl_rom_prot}, 32'h9);
    check("R2 ttb_base", ttb_base, 32'h0000_4000);
    check("R3 dom_perm", dom_perm, 32'hA5C3_1E2D);
    check("R3 domain2 field", {30'd0, dom_perm[5:4]}, 32'h2);

    // R8 flush-all pulse lasts one cycle
    wr_reg(4'd8, 3'd0, 32'h0);
    check("R8 all pulse", {30'd0, tlb_inv_all, tlb_inv_one}, 32'h2);
    @(negedge clk);
    check("R8 all drops", {30'd0, tlb_inv_all, tlb_inv_one}, 32'h0);
    wr_reg(4'd8, 3'd1, 32'hDEAD_B000);
    check("R8 one pulse", {30'd0, tlb_inv_all, tlb_inv_one}, 32'h1);
    check("R8 one addr", tlb_inv_addr, 32'hDEAD_B000);
    @(negedge clk);
    check("R8 one drops", {30'd0, tlb_inv_all, tlb_inv_one}, 32'h0);

    // R9 bad opcode on command register
    @(negedge clk);
    cp_wr_en = 1; cp_regnum = 4'd8; cp_opc2 = 3'd3; cp_wdata = 32'h1;
    #1;
    check("R9 bad op undef", {31'd0, cp_undef}, 32'h1);
    @(negedge clk);
    cp_wr_en = 0; cp_opc2 = 0;
    check("R9 bad op no pulse", {30'd0, tlb_inv_all, tlb_inv_one}, 32'h0);
    // R9 write to unimplemented flagged
    @(negedge clk);
    cp_wr_en = 1; cp_regnum = 4'd12;
    #1;
    check("R9 unimpl write undef", {31'd0, cp_undef}, 32'h1);
    @(negedge clk);
    cp_wr_en = 0;

    // R6 abort capture
    @(negedge clk);
    abt_valid = 1; abt_domain = 4'd9; abt_ftype = 4'hD; abt_addr = 32'hCAFE_0004;
    @(negedge clk);
    abt_valid = 0;
    rd_reg(4'd5, d, u);
    check("R6 fsr", d, 32'h0000_009D);
    rd_reg(4'd6, d, u);
    check("R6 far", d, 32'hCAFE_0004);

    // R7 abort against software write to register 5
    @(negedge clk);
    abt_valid = 1; abt_domain = 4'd3; abt_ftype = 4'd5; abt_addr = 32'h1111_2220;
    cp_wr_en = 1; cp_regnum = 4'd5; cp_wdata = 32'h0000_00AA;
    @(negedge clk);
    abt_valid = 0; cp_wr_en = 0;
    rd_reg(4'd5, d, u);
    check("R7 fsr collision", d, 32'h0000_0035);
    // R7 abort against software write to register 6
    @(negedge clk);
    abt_valid = 1; abt_domain = 4'd4; abt_ftype = 4'd1; abt_addr = 32'h2222_3330;
    cp_wr_en = 1; cp_regnum = 4'd6; cp_wdata = 32'h5555_5555;
    @(negedge clk);
    abt_valid = 0; cp_wr_en = 0;
    rd_reg(4'd6, d, u);
    check("R7 far collision", d, 32'h2222_3330);
    rd_reg(4'd5, d, u);
    check("R7 fsr alongside", d, 32'h0000_0041);

    // R10 reset during operation
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    check("R10 mid ctl", {28'd0, ctl_mmu_en, ctl_align_chk, ctl_sys_prot, ctl_rom_prot}, 32'h0);
    check("R10 mid dom", dom_perm, 32'h0);
    rst_n = 1;
    @(negedge clk);
    rd_reg(4'd5, d, u);
    check("R10 mid fsr", d, 32'h0);
    rd_reg(4'd2, d, u);
    check("R10 mid ttb", d, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule